// File: doc/BRIEF.md
# Memory Operand Address Generator

This block forms the 32-bit effective address of a load or store operand. A decoder presents a 3-bit addressing-mode code together with the values it has already read: a base register, an index register, a 3-bit scale code, a short 12-bit offset and a full 32-bit displacement. The block combines the terms that the mode calls for. Every sum is taken modulo 2^32.

Requests are accepted with a valid/ready handshake. The result is registered and appears one cycle after acceptance. It is held until the consumer takes it. Along with the address, the block reports which 1 GB region the address lies in and whether that is the shared top region. For indexed modes it also flags scale codes that have no defined meaning.

Top module: `operand_addr_gen`

## Requirements
- R1: Mode code 0 yields the 12-bit short offset zero-extended to 32 bits.
- R2: Mode code 1 yields the 32-bit displacement unchanged.
- R3: Mode code 2 yields the base register value.
- R4: Mode code 3 yields base plus the zero-extended short offset; mode code 4 yields base plus displacement.
- R5: Scale codes 0,1,2,3,4 multiply the index by 1,2,4,8,16. In an indexed mode (5, 6, 7), scale codes 5, 6 and 7 raise `rsp_scale_err` and the address is don't-care. A legal scale code leaves `rsp_scale_err` low.
- R6: Mode code 5 yields base + index×scale; mode code 6 yields index×scale + displacement; mode code 7 yields base + index×scale + displacement.
- R7: In modes 0 to 4 the index and scale code are ignored: the address does not depend on them and `rsp_scale_err` stays low, even for scale codes 5 to 7.
- R8: All additions and the index scaling wrap modulo 2^32 silently.
- R9: `rsp_region` equals address bits [31:30], and `rsp_shared` is high exactly when the region is 3.
- R10: `rsp_valid` is high in the cycle after a request is accepted (`req_valid` and `req_ready` high at a clock edge).
- R11: While `rsp_valid` is high and `rsp_ready` is low, the result stays valid and unchanged and `req_ready` is low.
- R12: A synchronous active-high reset clears `rsp_valid` and `rsp_scale_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_mode | input | 3 | Addressing-mode code 0..7 |
| req_base | input | 32 | Base register value |
| req_index | input | 32 | Index register value |
| req_scale | input | 3 | Scale code (0..4 legal) |
| req_short_ofs | input | 12 | Short offset, zero-extended |
| req_disp | input | 32 | Full displacement |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 32 | Effective address |
| rsp_scale_err | output | 1 | Illegal scale code in an indexed mode |
| rsp_region | output | 2 | Address bits [31:30] |
| rsp_shared | output | 1 | Address lies in region 3 |

## Verification
Every result, including the region and error flags, is due at the first clock edge after the accepting edge. The bench drives inputs on the falling edge and samples half a cycle after the next rising edge, so each check sees exactly that registered cycle. For back-pressure the bench holds `rsp_ready` low and re-samples on several later falling edges to confirm the held value and the low `req_ready`. The reset check samples on the falling edge after the reset edge.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    AM_OFS12        = 3'd0,
    AM_OFS32        = 3'd1,
    AM_REG          = 3'd2,
    AM_REG_OFS12    = 3'd3,
    AM_REG_DISP     = 3'd4,
    AM_REG_IDX      = 3'd5,
    AM_IDX_DISP     = 3'd6,
    AM_REG_IDX_DISP = 3'd7
  } amode_e;

  function automatic logic mode_uses_index(amode_e m);
    return (m == AM_REG_IDX) || (m == AM_IDX_DISP) || (m == AM_REG_IDX_DISP);
  endfunction

  function automatic logic mode_uses_base(amode_e m);
    return (m == AM_REG) || (m == AM_REG_OFS12) || (m == AM_REG_DISP) ||
           (m == AM_REG_IDX) || (m == AM_REG_IDX_DISP);
  endfunction

endpackage

// File: rtl/agu_scaler.sv
module agu_scaler #(
  parameter int AW        = 32,
  parameter int SCW       = 3,
  parameter int MAX_SHIFT = 4
) (
  input  logic [AW-1:0]  index,
  input  logic [SCW-1:0] scale_code,
  output logic [AW-1:0]  scaled,
  output logic           scale_ok
);

  localparam int NSHIFT = MAX_SHIFT + 1;

  logic [AW-1:0] shifted [NSHIFT];

  // one candidate per legal shift amount
  for (genvar g = 0; g < NSHIFT; g++) begin : g_shift
    assign shifted[g] = index << g;
  end

  always_comb begin
    scaled   = '0;
    scale_ok = 1'b0;
    for (int k = 0; k < NSHIFT; k++) begin
      if (scale_code == SCW'(k)) begin
        scaled   = shifted[k];
        scale_ok = 1'b1;
      end
    end
  end

endmodule

// File: rtl/agu_sum.sv
module agu_sum
  import agu_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 12
) (
  input  amode_e        mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] scaled_index,
  input  logic [OW-1:0] short_ofs,
  input  logic [AW-1:0] disp,
  output logic [AW-1:0] sum
);

  logic [AW-1:0] base_term;
  logic [AW-1:0] idx_term;
  logic [AW-1:0] ofs_term;

  always_comb begin
    base_term = mode_uses_base(mode)  ? base         : '0;
    idx_term  = mode_uses_index(mode) ? scaled_index : '0;
    unique case (mode)
      AM_OFS12, AM_REG_OFS12:                          ofs_term = AW'(short_ofs);
      AM_OFS32, AM_REG_DISP, AM_IDX_DISP, AM_REG_IDX_DISP: ofs_term = disp;
      default:                                         ofs_term = '0;
    endcase
    sum = base_term + idx_term + ofs_term;
  end

endmodule

// File: rtl/agu_out_reg.sv
module agu_out_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] addr_d,
  input  logic          err_d,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] addr_q,
  output logic          err_q
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      err_q     <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      err_q     <= err_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // address register carries no reset so it maps onto plain fabric flops
  always_ff @(posedge clk) begin
    if (take) addr_q <= addr_d;
  end

  // R11
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(addr_q) && $stable(err_q)));

  // R10
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

endmodule

// File: rtl/operand_addr_gen.sv
module operand_addr_gen
  import agu_pkg::*;
#(
  parameter int AW        = 32,
  parameter int OW        = 12,
  parameter int SCW       = 3,
  parameter int MAX_SHIFT = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [2:0]     req_mode,
  input  logic [AW-1:0]  req_base,
  input  logic [AW-1:0]  req_index,
  input  logic [SCW-1:0] req_scale,
  input  logic [OW-1:0]  req_short_ofs,
  input  logic [AW-1:0]  req_disp,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [AW-1:0]  rsp_addr,
  output logic           rsp_scale_err,
  output logic [1:0]     rsp_region,
  output logic           rsp_shared
);

  amode_e        mode;
  logic [AW-1:0] scaled;
  logic          scale_ok;
  logic [AW-1:0] ea;
  logic          err_d;

  assign mode  = amode_e'(req_mode);
  assign err_d = mode_uses_index(mode) && !scale_ok;

  agu_scaler #(.AW(AW), .SCW(SCW), .MAX_SHIFT(MAX_SHIFT)) u_scaler (
    .index      (req_index),
    .scale_code (req_scale),
    .scaled     (scaled),
    .scale_ok   (scale_ok)
  );

  agu_sum #(.AW(AW), .OW(OW)) u_sum (
    .mode         (mode),
    .base         (req_base),
    .scaled_index (scaled),
    .short_ofs    (req_short_ofs),
    .disp         (req_disp),
    .sum          (ea)
  );

  agu_out_reg #(.AW(AW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .addr_d    (ea),
    .err_d     (err_d),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .addr_q    (rsp_addr),
    .err_q     (rsp_scale_err)
  );

  assign rsp_region = rsp_addr[AW-1:AW-2];
  assign rsp_shared = &rsp_region;

  // R11
  block_input_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R5
  scale_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_mode >= 3'd5 && req_scale > SCW'(MAX_SHIFT))
      |=> rsp_scale_err);

  // R3
  reg_indirect_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_mode == 3'd2) |=> (rsp_addr == $past(req_base)));

  // R7
  no_idx_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_mode < 3'd5) |=> !rsp_scale_err);

endmodule

// File: tb/test_operand_addr_gen.sv
module test_operand_addr_gen;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready;
  logic [2:0]  req_mode;
  logic [31:0] req_base, req_index, req_disp;
  logic [2:0]  req_scale;
  logic [11:0] req_short_ofs;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_addr;
  logic        rsp_scale_err;
  logic [1:0]  rsp_region;
  logic        rsp_shared;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  operand_addr_gen i_operand_addr_gen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_base(req_base), .req_index(req_index),
    .req_scale(req_scale), .req_short_ofs(req_short_ofs), .req_disp(req_disp),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_scale_err(rsp_scale_err), .rsp_region(rsp_region), .rsp_shared(rsp_shared)
  );

  typedef struct packed {
    logic [2:0]  m;
    logic [31:0] b;
    logic [31:0] x;
    logic [2:0]  s;
    logic [11:0] o;
    logic [31:0] d;
    logic [31:0] ea;
    logic        ee;
    logic        chk_a;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h1234_5678, 32'h0, 3'd0, 12'hABC, 32'h0,         32'h0000_0ABC, 1'b0, 1'b1, 4'd1},  // R1
    '{3'd1, 32'h0,         32'h0, 3'd0, 12'h0,   32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 1'b1, 4'd2},  // R2
    '{3'd2, 32'h4000_0010, 32'h0, 3'd0, 12'h0,   32'h0,         32'h4000_0010, 1'b0, 1'b1, 4'd3},  // R3
    '{3'd3, 32'h1000_0000, 32'h0, 3'd0, 12'hFFF, 32'h0,         32'h1000_0FFF, 1'b0, 1'b1, 4'd4},  // R4
    '{3'd4, 32'h1000_0000, 32'h0, 3'd0, 12'h0,   32'h0000_0100, 32'h1000_0100, 1'b0, 1'b1, 4'd4},  // R4
    '{3'd5, 32'h100,       32'h3, 3'd4, 12'h0,   32'h0,         32'h0000_0130, 1'b0, 1'b1, 4'd6},  // R6
    '{3'd6, 32'h0,         32'h5, 3'd2, 12'h0,   32'h8000_0000, 32'h8000_0014, 1'b0, 1'b1, 4'd6},  // R6
    '{3'd7, 32'h1000,      32'h2, 3'd3, 12'h0,   32'h20,        32'h0000_1030, 1'b0, 1'b1, 4'd6},  // R6
    '{3'd5, 32'h0,         32'h7, 3'd0, 12'h0,   32'h0,         32'h0000_0007, 1'b0, 1'b1, 4'd5},  // R5
    '{3'd5, 32'h0,         32'h7, 3'd1, 12'h0,   32'h0,         32'h0000_000E, 1'b0, 1'b1, 4'd5},  // R5
    '{3'd4, 32'hFFFF_FFF0, 32'h0, 3'd0, 12'h0,   32'h20,        32'h0000_0010, 1'b0, 1'b1, 4'd8},  // R8
    '{3'd7, 32'hC000_0000, 32'h1000_0000, 3'd4, 12'h0, 32'h0,   32'hC000_0000, 1'b0, 1'b1, 4'd8},  // R8
    '{3'd2, 32'h8000_0000, 32'hFFFF, 3'd7, 12'h0, 32'h0,        32'h8000_0000, 1'b0, 1'b1, 4'd7},  // R7
    '{3'd6, 32'h0,         32'h1, 3'd5, 12'h0,   32'h0,         32'h0,         1'b1, 1'b0, 4'd5}   // R5
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_mode      = v.m;
    req_base      = v.b;
    req_index     = v.x;
    req_scale     = v.s;
    req_short_ofs = v.o;
    req_disp      = v.d;
    req_valid     = 1'b1;
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; rsp_ready = 1'b1;
    req_mode = '0; req_base = '0; req_index = '0; req_scale = '0;
    req_short_ofs = '0; req_disp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    check(rsp_valid == 1'b0, "R12 valid after reset", 32'(rsp_valid), 32'h0);
    check(rsp_scale_err == 1'b0, "R12 err after reset", 32'(rsp_scale_err), 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vec %0d", v.rq, i);
      @(negedge clk);
      drive(v);
      check(req_ready == 1'b1, {tag, " ready"}, 32'(req_ready), 32'h1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      // R10 result is present one edge after acceptance
      check(rsp_valid == 1'b1, {"R10 ", tag}, 32'(rsp_valid), 32'h1);
      check(rsp_scale_err == v.ee, {tag, " err"}, 32'(rsp_scale_err), 32'(v.ee));
      if (v.chk_a) begin
        check(rsp_addr == v.ea, {tag, " addr"}, rsp_addr, v.ea);
        // R9 region and shared flag
        check(rsp_region == v.ea[31:30], "R9 region", 32'(rsp_region), 32'(v.ea[31:30]));
        check(rsp_shared == (v.ea[31:30] == 2'd3), "R9 shared",
              32'(rsp_shared), 32'(v.ea[31:30] == 2'd3));
      end
    end

    // R7: same mode 3 request, different index/scale, same address
    @(negedge clk);
    drive('{3'd3, 32'h2000_0000, 32'hFFFF_FFFF, 3'd6, 12'h00F, 32'h0, 32'h0, 1'b0, 1'b0, 4'd7});
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    check(rsp_addr == 32'h2000_000F, "R7 index ignored", rsp_addr, 32'h2000_000F);
    check(rsp_scale_err == 1'b0, "R7 no err", 32'(rsp_scale_err), 32'h0);

    // back-pressure: R11
    @(negedge clk);
    rsp_ready = 1'b0;
    drive('{3'd1, 32'h0, 32'h0, 3'd0, 12'h0, 32'hC000_1234, 32'h0, 1'b0, 1'b0, 4'd11});
    @(posedge clk); @(negedge clk);
    req_disp = 32'h0000_5555;  // new request waiting, must not be taken
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); @(negedge clk);
      check(rsp_valid == 1'b1, "R11 valid held", 32'(rsp_valid), 32'h1);
      check(rsp_addr == 32'hC000_1234, "R11 addr held", rsp_addr, 32'hC000_1234);
      check(req_ready == 1'b0, "R11 ready low", 32'(req_ready), 32'h0);
    end
    check(rsp_shared == 1'b1, "R9 shared region 3", 32'(rsp_shared), 32'h1);
    rsp_ready = 1'b1;  // consume; pending request taken in the same edge
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, "R10 queued request", 32'(rsp_valid), 32'h1);
    check(rsp_addr == 32'h0000_5555, "R2 queued request", rsp_addr, 32'h0000_5555);
    @(posedge clk); @(negedge clk);
    check(rsp_valid == 1'b0, "R11 drained", 32'(rsp_valid), 32'h0);

    // R12: reset clears a pending error result
    rsp_ready = 1'b0;
    drive('{3'd7, 32'h0, 32'h1, 3'd7, 12'h0, 32'h0, 32'h0, 1'b1, 1'b0, 4'd12});
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check(rsp_scale_err == 1'b1, "R5 err before reset", 32'(rsp_scale_err), 32'h1);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(rsp_valid == 1'b0, "R12 valid cleared", 32'(rsp_valid), 32'h0);
    check(rsp_scale_err == 1'b0, "R12 err cleared", 32'(rsp_scale_err), 32'h0);
    rst = 1'b0;
    rsp_ready = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule